// File: doc/BRIEF.md
# Device Boot Sequencer

This block steps a programmable device from power-on to normal running. After reset it waits out a fixed power-up delay. It then enters an initialization phase and holds there while any restart request is active. Next comes a loading phase, in which it counts clock cycles and watches a stream of 24-bit words. When loading is finished, a short start-up phase releases the internal reset, raises `done` and finally enables the user I/O. The status pins `init_n`, `hdc` and `ldc_n` show which phase is active. `dout` forwards the serial input only while loading.

Loading ends only when two conditions both hold. The cycle count kept since loading began must have equalled the length captured from the stream, and an end-of-load strobe must have been seen. A sync word marks where the length lies: the first valid word after that sync word is the length. A master/slave select adds extra initialization cycles in master mode, so that chained devices have time to become ready. A restart request or a bit error during loading sends the sequencer back to initialization. In start-up and operation, only a program request can do that.

Top module: `cfg_seq_top`

## Requirements
- R1: While `rst` is high, and for PWR_CYCLES (16) cycles after it falls, the outputs are `init_n`=0, `hdc`=1, `ldc_n`=0, `done`=0, `io_en`=0, `core_rst`=1. `init_n` first rises at the PWR_CYCLES+INIT_CYCLES-th clock edge after `rst` falls when `master_sel`=0.
- R2: During initialization the outputs are `init_n`=0, `hdc`=1, `ldc_n`=0. While `rst_req_n`, `prog_n` or `init_hold_n` is low, the sequencer stays in initialization. Once all three are high, initialization lasts INIT_CYCLES (4) further cycles.
- R3: With `master_sel`=1, initialization lasts MASTER_EXT (8) more cycles than with `master_sel`=0.
- R4: During loading the outputs are `init_n`=1, `hdc`=1, `ldc_n`=0, and `dout` equals `ser_in`. In every other phase `dout` is 0.
- R5: A cycle counter is cleared to 0 on entry to loading and increases by one on every loading cycle.
- R6: The first word with `cfg_valid`=1 after a word equal to 24'h5A3C96 is captured as the length L. Suppose the strobe `cfg_end` is seen in loading cycle E, where cycle 0 is the first loading cycle. Then start-up begins in loading cycle max(L,E)+2. With no `cfg_end`, loading never ends.
- R7: During loading, a low on `rst_req_n`, `prog_n` or `init_hold_n`, or a high on `bit_err`, returns the sequencer to initialization on the next edge.
- R8: Start-up lasts three cycles, in this order: (`core_rst`=1, `done`=0), then (`core_rst`=0, `done`=0), then (`core_rst`=0, `done`=1). Operation follows with `done`=1 and `io_en`=1. In start-up and operation, `hdc`=0 and `ldc_n`=1.
- R9: In start-up or operation, `prog_n` low returns the sequencer to initialization on the next edge. In those phases, `rst_req_n` low and `bit_err` high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each cycle is one configuration clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| rst_req_n | input | 1 | Active-low restart request |
| prog_n | input | 1 | Active-low program request |
| init_hold_n | input | 1 | Active-low external hold of initialization |
| master_sel | input | 1 | 1 = master mode (longer initialization) |
| bit_err | input | 1 | Bit error detected in the load stream |
| cfg_valid | input | 1 | `cfg_word` carries a word this cycle |
| cfg_word | input | 24 | Load stream word (sync word, then length) |
| cfg_end | input | 1 | End-of-load frame strobe |
| ser_in | input | 1 | Serial data forwarded to `dout` while loading |
| init_n | output | 1 | Low during power-up and initialization |
| hdc | output | 1 | High until start-up |
| ldc_n | output | 1 | Low until start-up |
| done | output | 1 | Boot complete |
| dout | output | 1 | Pass-through of `ser_in` while loading |
| core_rst | output | 1 | Internal reset of user flip-flops |
| io_en | output | 1 | User I/O enable |

## Verification
The bench varies the captured length against the cycle in which the end strobe arrives. A design that ends loading on only one of the two conditions, or that compares the count one cycle off, starts up in the wrong loading cycle. It also holds initialization low with a request, raises a bit error in the middle of loading, and toggles the inputs that must be ignored while the device is operating. A wrong design would, in these cases, miss the hold, keep loading after the error, or drop `io_en`. Boot timing is measured in both master and slave mode. If the extra master cycles are missing or wrongly counted, the rise of `init_n` lands on the wrong edge.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_INIT,
        ST_LOAD,
        ST_START,
        ST_OPER
    } seq_state_e;

    typedef struct packed {
        logic init_n;
        logic hdc;
        logic ldc_n;
        logic done;
        logic core_rst;
        logic io_en;
        logic dout_en;
    } pin_set_t;

    localparam logic [23:0] SYNC_WORD = 24'h5A3C96;
    localparam int SU_CYCLES = 3;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Output levels per phase; start-up phase split by first/last cycle
    function automatic pin_set_t pins_for(input seq_state_e s,
                                          input logic su_first,
                                          input logic su_last);
        pin_set_t p;
        p = '{init_n: 1'b0, hdc: 1'b1, ldc_n: 1'b0, done: 1'b0,
              core_rst: 1'b1, io_en: 1'b0, dout_en: 1'b0};
        case (s)
            ST_LOAD: begin
                p.init_n  = 1'b1;
                p.dout_en = 1'b1;
            end
            ST_START: begin
                p.init_n   = 1'b1;
                p.hdc      = 1'b0;
                p.ldc_n    = 1'b1;
                p.core_rst = su_first;
                p.done     = su_last;
            end
            ST_OPER: begin
                p.init_n   = 1'b1;
                p.hdc      = 1'b0;
                p.ldc_n    = 1'b1;
                p.core_rst = 1'b0;
                p.done     = 1'b1;
                p.io_en    = 1'b1;
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/cfg_seq_delay.sv
module cfg_seq_delay #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (run)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/cfg_seq_len.sv
module cfg_seq_len
    import cfg_seq_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word,
    input  logic              end_strobe,
    output logic              len_done
);

    logic [WORD_W-1:0] cyc_cnt;
    logic [WORD_W-1:0] len_q;
    logic              sync_seen;
    logic              len_ok;
    logic              hit_q;
    logic              eof_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cyc_cnt   <= '0;
            len_q     <= '0;
            sync_seen <= 1'b0;
            len_ok    <= 1'b0;
            hit_q     <= 1'b0;
            eof_q     <= 1'b0;
        end else begin
            cyc_cnt <= cyc_cnt + 1'b1;
            if (word_valid && !sync_seen && word == WORD_W'(SYNC_WORD))
                sync_seen <= 1'b1;
            else if (word_valid && sync_seen && !len_ok) begin
                len_q  <= word;
                len_ok <= 1'b1;
            end
            if (len_ok && cyc_cnt == len_q)
                hit_q <= 1'b1;
            if (end_strobe)
                eof_q <= 1'b1;
        end
    end

    assign len_done = hit_q && eof_q;

    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> cyc_cnt == '0); // R5
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active)) |-> cyc_cnt == $past(cyc_cnt) + 1'b1); // R5
    AST_DONE_NEEDS_LEN: assert property (@(posedge clk) disable iff (rst)
        $rose(len_done) |-> len_ok); // R6

endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top
    import cfg_seq_pkg::*;
#(
    parameter int PWR_CYCLES  = 16,
    parameter int INIT_CYCLES = 4,
    parameter int MASTER_EXT  = 8,
    parameter int WORD_W      = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_req_n,
    input  logic              prog_n,
    input  logic              init_hold_n,
    input  logic              master_sel,
    input  logic              bit_err,
    input  logic              cfg_valid,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic              cfg_end,
    input  logic              ser_in,
    output logic              init_n,
    output logic              hdc,
    output logic              ldc_n,
    output logic              done,
    output logic              dout,
    output logic              core_rst,
    output logic              io_en
);

    localparam int DLY_MAX = max3(PWR_CYCLES, INIT_CYCLES + MASTER_EXT, SU_CYCLES);
    localparam int DLY_W   = $clog2(DLY_MAX + 1);

    seq_state_e        st, nxt;
    logic [DLY_W-1:0]  dly_cnt;
    logic [DLY_W-1:0]  init_last;
    logic              hold;
    logic              any_req_low;
    logic              len_done;
    logic              su_first, su_last;
    pin_set_t          pins;

    assign any_req_low = !rst_req_n || !prog_n || !init_hold_n;
    assign init_last   = master_sel ? DLY_W'(INIT_CYCLES + MASTER_EXT - 1)
                                    : DLY_W'(INIT_CYCLES - 1);
    assign su_first    = (dly_cnt == '0);
    assign su_last     = (dly_cnt == DLY_W'(SU_CYCLES - 1));

    always_comb begin
        nxt  = st;
        hold = 1'b0;
        case (st)
            ST_PWRUP: if (dly_cnt == DLY_W'(PWR_CYCLES - 1)) nxt = ST_INIT;
            ST_INIT: begin
                if (any_req_low)             hold = 1'b1;
                else if (dly_cnt == init_last) nxt = ST_LOAD;
            end
            ST_LOAD: begin
                if (any_req_low || bit_err) nxt = ST_INIT;
                else if (len_done)          nxt = ST_START;
            end
            ST_START: begin
                if (!prog_n)     nxt = ST_INIT;
                else if (su_last) nxt = ST_OPER;
            end
            ST_OPER: if (!prog_n) nxt = ST_INIT;
            default: nxt = ST_PWRUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_PWRUP;
        else     st <= nxt;
    end

    cfg_seq_delay #(.CNT_W(DLY_W)) u_delay (
        .clk   (clk),
        .rst   (rst),
        .clear (hold || (nxt != st)),
        .run   (st != ST_OPER),
        .cnt   (dly_cnt)
    );

    cfg_seq_len #(.WORD_W(WORD_W)) u_len (
        .clk        (clk),
        .rst        (rst),
        .active     (st == ST_LOAD),
        .word_valid (cfg_valid),
        .word       (cfg_word),
        .end_strobe (cfg_end),
        .len_done   (len_done)
    );

    assign pins     = pins_for(st, su_first, su_last);
    assign init_n   = pins.init_n;
    assign hdc      = pins.hdc;
    assign ldc_n    = pins.ldc_n;
    assign done     = pins.done;
    assign core_rst = pins.core_rst;
    assign io_en    = pins.io_en;
    assign dout     = pins.dout_en & ser_in;

    AST_INIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st == ST_INIT && any_req_low) |=> st == ST_INIT); // R2
    AST_LOAD_ABORT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LOAD && bit_err) |=> st == ST_INIT); // R7
    AST_EXIT_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
        (st == ST_START && $past(st) == ST_LOAD) |-> $past(len_done)); // R6
    AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (!core_rst && $past(!core_rst))); // R8
    AST_IO_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        io_en |-> done); // R8
    AST_PROG_RESTART: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_START || st == ST_OPER) && !prog_n) |=> st == ST_INIT); // R9

endmodule

// File: tb/cfg_seq_top_test.sv
module cfg_seq_top_test;

    localparam int PWR  = 16;
    localparam int INIT = 4;
    localparam int EXT  = 8;
    localparam logic [23:0] SYNC = 24'h5A3C96;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rst_req_n = 1'b1, prog_n = 1'b1, init_hold_n = 1'b1;
    logic master_sel = 1'b0, bit_err = 1'b0;
    logic cfg_valid = 1'b0, cfg_end = 1'b0, ser_in = 1'b0;
    logic [23:0] cfg_word = '0;
    logic init_n, hdc, ldc_n, done, dout, core_rst, io_en;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    cfg_seq_top uut (
        .clk(clk), .rst(rst), .rst_req_n(rst_req_n), .prog_n(prog_n),
        .init_hold_n(init_hold_n), .master_sel(master_sel), .bit_err(bit_err),
        .cfg_valid(cfg_valid), .cfg_word(cfg_word), .cfg_end(cfg_end),
        .ser_in(ser_in), .init_n(init_n), .hdc(hdc), .ldc_n(ldc_n),
        .done(done), .dout(dout), .core_rst(core_rst), .io_en(io_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_boot(input bit m);
        return INIT + (m ? EXT : 0);
    endfunction

    function automatic int exp_load(input int l, input int e);
        return ((l > e) ? l : e) + 2;
    endfunction

    // reset, then count edges until init_n rises
    task automatic boot(input bit m);
        int n;
        master_sel = m;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(init_n == 0 && hdc == 1 && ldc_n == 0 && done == 0 && io_en == 0 && core_rst == 1,
            "R1 reset levels", {init_n, hdc, ldc_n, done, io_en, core_rst}, 6'b010001);
        rst = 1'b0;
        n = 0;
        while (n < 200) begin
            @(negedge clk);
            n++;
            if (init_n) break;
        end
        chk(n == PWR + exp_boot(m), m ? "R3 master boot" : "R1 R2 slave boot", n, PWR + exp_boot(m));
    endtask

    // count cycles from a release point until init_n rises
    task automatic wait_rise(output int n);
        n = 0;
        while (n < 200) begin
            @(negedge clk);
            n++;
            if (init_n) break;
        end
    endtask

    // called at loading cycle 0; returns cycle index at which hdc fell
    task automatic run_load(input int l, input int e, input int limit, output int k);
        k = 0;
        while (k < limit) begin
            if (k > 0) @(negedge clk);
            if (!hdc) break;
            cfg_valid = (k == 0 || k == 1);
            cfg_word  = (k == 0) ? SYNC : 24'(l);
            cfg_end   = (k == e);
            ser_in    = 1'($urandom);
            #1;
            if (k == 1) begin
                chk(dout == ser_in, "R4 dout pass", dout, ser_in);
                chk(init_n == 1 && hdc == 1 && ldc_n == 0, "R4 load levels",
                    {init_n, hdc, ldc_n}, 3'b110);
            end
            k++;
        end
        cfg_valid = 1'b0;
        cfg_end   = 1'b0;
    endtask

    task automatic startup_seq;
        chk(core_rst == 1 && done == 0 && hdc == 0 && ldc_n == 1, "R8 start hold",
            {core_rst, done, hdc, ldc_n}, 4'b1001);
        @(negedge clk);
        chk(core_rst == 0 && done == 0, "R8 release", {core_rst, done}, 2'b00);
        @(negedge clk);
        chk(done == 1 && io_en == 0, "R8 done", {done, io_en}, 2'b10);
        @(negedge clk);
        ser_in = 1'b1;
        #1;
        chk(io_en == 1 && done == 1 && dout == 0, "R8 R4 operate",
            {io_en, done, dout}, 3'b110);
    endtask

    initial begin
        int k, n, l, e;
        bit m;
        void'($urandom(32'd20240611));

        // directed: slave boot, early end strobe
        boot(1'b0);
        run_load(10, 3, 200, k);
        chk(k == exp_load(10, 3), "R5 R6 count governs", k, exp_load(10, 3));
        startup_seq();

        // ignored inputs in operation
        @(negedge clk);
        rst_req_n = 1'b0; bit_err = 1'b1;
        repeat (4) @(negedge clk);
        chk(io_en == 1 && init_n == 1, "R9 ignore reset/err", io_en, 1);
        rst_req_n = 1'b1; bit_err = 1'b0;
        prog_n = 1'b0;
        @(negedge clk);
        chk(init_n == 0 && done == 0 && io_en == 0, "R9 prog restart", init_n, 0);
        prog_n = 1'b1;
        wait_rise(n);
        chk(n == INIT, "R2 reinit length", n, INIT);
        run_load(4, 20, 200, k);
        chk(k == exp_load(4, 20), "R6 end strobe governs", k, exp_load(4, 20));
        startup_seq();

        // hold in initialization
        prog_n = 1'b0;
        boot_hold: begin
            master_sel = 1'b0;
            rst = 1'b1;
            repeat (3) @(posedge clk);
            @(negedge clk);
            rst = 1'b0;
            repeat (40) @(negedge clk);
            chk(init_n == 0 && hdc == 1 && ldc_n == 0, "R2 held low", init_n, 0);
            prog_n = 1'b1;
            wait_rise(n);
            chk(n == INIT, "R2 release length", n, INIT);
        end

        // bit error mid-load, then restart request mid-load
        run_load(30, 1, 3, k);
        bit_err = 1'b1;
        @(negedge clk);
        chk(init_n == 0, "R7 bit error abort", init_n, 0);
        bit_err = 1'b0;
        wait_rise(n);
        chk(n == INIT, "R7 restart length", n, INIT);
        run_load(30, 1, 4, k);
        init_hold_n = 1'b0;
        @(negedge clk);
        chk(init_n == 0, "R7 hold abort", init_n, 0);
        init_hold_n = 1'b1;
        wait_rise(n);
        run_load(30, 1, 3, k);
        rst_req_n = 1'b0;
        @(negedge clk);
        chk(init_n == 0, "R7 reset abort", init_n, 0);
        rst_req_n = 1'b1;

        // count matches but no end strobe: stays loading
        boot(1'b1);
        run_load(5, 1000, 40, k);
        chk(hdc == 1 && init_n == 1, "R6 no end strobe", hdc, 1);

        // random boots
        for (int i = 0; i < 8; i++) begin
            m = 1'($urandom);
            l = 3 + int'($urandom % 38);
            e = int'($urandom % 46);
            boot(m);
            run_load(l, e, 200, k);
            chk(k == exp_load(l, e), "R6 random load", k, exp_load(l, e));
            startup_seq();
        end

        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

endmodule